// File: doc/BRIEF.md
# Word Load Address Generator

This block turns one 32-bit word-load instruction, delivered as two 16-bit halfwords, into the facts that a load pipeline needs before it touches memory. From the halfwords, the current program counter and the values of the base and index registers, it works out which addressing form the instruction uses. It then produces the effective address, whether the base register is to be updated and with what value, and whether the access must run at user privilege. Encodings that fall outside the supported forms raise an undefined-instruction flag.

The caller presents an instruction with `in_valid` high for one cycle. One clock later the results appear on registered outputs, with `out_valid` high. The registered outputs hold their last values while no new instruction is presented. The memory access, the register file, alignment checking and any other load width are left to neighbouring logic.

Top module: `word_load_agen`

## Requirements
- R1: Literal form: when the base field `hw0[3:0]` equals 15, the address is ((pc + 3) with bits 1:0 cleared) plus the 12-bit value `hw1[11:0]` if `hw0[7]` is 1, or minus it if `hw0[7]` is 0. There is no writeback, and `user_acc` and `undef` are 0.
- R2: Register form: when the base field is not 15, `hw0[7]` is 0, the mode code `hw1[11:8]` is 0 and `hw1[7:6]` is 0, the address is base_val + (index_val << `hw1[5:4]`). There is no writeback.
- R3: Positive 12-bit form: when the base field is not 15 and `hw0[7]` is 1, the address is base_val + `hw1[11:0]`, zero-extended. There is no writeback.
- R4: Post-indexed forms, with the base field not 15 and `hw0[7]` 0: mode code 0x9 gives address base_val and writeback value base_val − `hw1[7:0]`; mode code 0xB gives address base_val and writeback value base_val + `hw1[7:0]`. `wb_en` is 1 in both.
- R5: Mode code 0xC gives the address base_val − `hw1[7:0]` with `wb_en` 0.
- R6: Pre-indexed forms: mode code 0xD gives address and writeback value base_val − `hw1[7:0]`; mode code 0xF gives address and writeback value base_val + `hw1[7:0]`. `wb_en` is 1 in both.
- R7: Mode code 0xE gives the address base_val + `hw1[7:0]`, `wb_en` 0 and `user_acc` 1. `user_acc` is 0 for every other form.
- R8: Any other encoding on the mode-code path (codes 0x1 to 0x8 and 0xA, or code 0x0 with `hw1[7:6]` not 0) sets `undef` to 1, with `wb_en` 0, `user_acc` 0 and `ea` 0.
- R9: All address and writeback arithmetic wraps modulo 2^32.
- R10: Outputs are registered: the results of an instruction presented with `in_valid` high appear one clock later with `out_valid` high. `out_valid` is low in the cycle after `in_valid` is low. An active-low synchronous reset clears `out_valid`, and the data outputs keep their values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| hw0 | input | 16 | First instruction halfword |
| hw1 | input | 16 | Second instruction halfword |
| pc | input | 32 | Program counter value for literal addressing |
| base_val | input | 32 | Value of the base register |
| index_val | input | 32 | Value of the index register |
| out_valid | output | 1 | Registered results are valid |
| ea | output | 32 | Effective memory address |
| wb_en | output | 1 | Base register is to be written back |
| wb_val | output | 32 | New base register value |
| user_acc | output | 1 | Access must be performed at user privilege |
| undef | output | 1 | Encoding is not a supported word-load form |

## Verification
A wrong mode classification inside the decoder shows up at the ports one clock after the instruction, as a wrong address, a wrong writeback flag or a wrong privilege flag. Each addressing form therefore gets its own directed instruction with operands chosen so that neighbouring forms give different addresses. Errors in the output register stage show up as `out_valid` out of step with `in_valid`, or as data outputs that drift while idle. Those are checked in the cycles after an instruction and across a reset.

// File: rtl/wla_pkg.sv
// Shared types for the word load address generator.
// Assumes a single 32-bit instruction made of two 16-bit halfwords.
package wla_pkg;

    localparam int HALF_W = 16;

    typedef enum logic [3:0] {
        AM_LITERAL,
        AM_REG_SHIFT,
        AM_POS_IMM12,
        AM_POST_SUB,
        AM_POST_ADD,
        AM_NEG_IMM8,
        AM_PRE_SUB,
        AM_PRE_ADD,
        AM_USER,
        AM_BAD
    } addr_mode_e;

endpackage

// File: rtl/wla_decode.sv
// Classifies the instruction halfwords into an addressing form and pulls out
// the offset fields. Assumes the instruction already belongs to the word-load
// group; only the bits that choose among its forms are examined.
module wla_decode
    import wla_pkg::*;
(
    input  logic [HALF_W-1:0] hw0,
    input  logic [HALF_W-1:0] hw1,
    output addr_mode_e        mode,
    output logic              lit_up,
    output logic [11:0]       imm12,
    output logic [7:0]        imm8,
    output logic [1:0]        shamt
);

    localparam logic [3:0] LIT_BASE = 4'hF;

    logic [3:0] base_sel;
    logic [3:0] code;

    assign base_sel = hw0[3:0];
    assign code     = hw1[11:8];
    assign lit_up   = hw0[7];
    assign imm12    = hw1[11:0];
    assign imm8     = hw1[7:0];
    assign shamt    = hw1[5:4];

    // Pick the addressing form; literal wins, then the 12-bit selector, then the mode code.
    always_comb begin
        if (base_sel == LIT_BASE) begin
            mode = AM_LITERAL;
        end else if (hw0[7]) begin
            mode = AM_POS_IMM12;
        end else begin
            unique case (code)
                4'h0:    mode = (hw1[7:6] == 2'b00) ? AM_REG_SHIFT : AM_BAD;
                4'h9:    mode = AM_POST_SUB;
                4'hB:    mode = AM_POST_ADD;
                4'hC:    mode = AM_NEG_IMM8;
                4'hD:    mode = AM_PRE_SUB;
                4'hE:    mode = AM_USER;
                4'hF:    mode = AM_PRE_ADD;
                default: mode = AM_BAD;
            endcase
        end
    end

endmodule

// File: rtl/wla_agen.sv
// Computes effective address, writeback value and flags from the decoded form.
// Purely combinational; all arithmetic wraps at ADDR_W bits.
module wla_agen
    import wla_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  addr_mode_e        mode,
    input  logic              lit_up,
    input  logic [11:0]       imm12,
    input  logic [7:0]        imm8,
    input  logic [1:0]        shamt,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_val,
    output logic              user_acc,
    output logic              undef
);

    logic [ADDR_W-1:0] pc_up;
    logic [ADDR_W-1:0] off12;
    logic [ADDR_W-1:0] off8;
    logic [ADDR_W-1:0] base_plus8;
    logic [ADDR_W-1:0] base_minus8;

    // Round the program counter up to a word boundary.
    always_comb pc_up = (pc + ADDR_W'(3)) & ~ADDR_W'(3);

    // Zero-extend offsets and form the two short-offset sums once.
    always_comb begin
        off12       = ADDR_W'(imm12);
        off8        = ADDR_W'(imm8);
        base_plus8  = base_val + off8;
        base_minus8 = base_val - off8;
    end

    // Select address, writeback and flags for each form.
    always_comb begin
        ea       = '0;
        wb_en    = 1'b0;
        wb_val   = base_val;
        user_acc = 1'b0;
        undef    = 1'b0;
        unique case (mode)
            AM_LITERAL:   ea = lit_up ? pc_up + off12 : pc_up - off12;
            AM_REG_SHIFT: ea = base_val + (index_val << shamt);
            AM_POS_IMM12: ea = base_val + off12;
            AM_POST_SUB:  begin ea = base_val;    wb_en = 1'b1; wb_val = base_minus8; end
            AM_POST_ADD:  begin ea = base_val;    wb_en = 1'b1; wb_val = base_plus8;  end
            AM_NEG_IMM8:  ea = base_minus8;
            AM_PRE_SUB:   begin ea = base_minus8; wb_en = 1'b1; wb_val = base_minus8; end
            AM_PRE_ADD:   begin ea = base_plus8;  wb_en = 1'b1; wb_val = base_plus8;  end
            AM_USER:      begin ea = base_plus8;  user_acc = 1'b1; end
            default:      undef = 1'b1;
        endcase
    end

endmodule

// File: rtl/word_load_agen.sv
// Top of the word load address generator: decode, address arithmetic and a
// one-cycle output register. Data outputs load only when in_valid is high.
module word_load_agen
    import wla_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       hw0,
    input  logic [15:0]       hw1,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_val,
    output logic              user_acc,
    output logic              undef
);

    addr_mode_e        mode;
    logic              lit_up;
    logic [11:0]       imm12;
    logic [7:0]        imm8;
    logic [1:0]        shamt;
    logic [ADDR_W-1:0] ea_c;
    logic [ADDR_W-1:0] wb_val_c;
    logic              wb_en_c;
    logic              user_c;
    logic              undef_c;

    wla_decode u_dec (
        .hw0   (hw0),
        .hw1   (hw1),
        .mode  (mode),
        .lit_up(lit_up),
        .imm12 (imm12),
        .imm8  (imm8),
        .shamt (shamt)
    );

    wla_agen #(.ADDR_W(ADDR_W)) u_agen (
        .mode     (mode),
        .lit_up   (lit_up),
        .imm12    (imm12),
        .imm8     (imm8),
        .shamt    (shamt),
        .pc       (pc),
        .base_val (base_val),
        .index_val(index_val),
        .ea       (ea_c),
        .wb_en    (wb_en_c),
        .wb_val   (wb_val_c),
        .user_acc (user_c),
        .undef    (undef_c)
    );

    // Valid flag follows in_valid by one cycle; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture results when an instruction is presented; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            wb_en    <= 1'b0;
            wb_val   <= '0;
            user_acc <= 1'b0;
            undef    <= 1'b0;
        end else if (in_valid) begin
            ea       <= ea_c;
            wb_en    <= wb_en_c;
            wb_val   <= wb_val_c;
            user_acc <= user_c;
            undef    <= undef_c;
        end
    end

endmodule

// File: rtl/word_load_agen_chk.sv
// Assertion checker for word_load_agen, attached by bind below.
module word_load_agen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       hw0,
    input logic [15:0]       hw1,
    input logic [ADDR_W-1:0] base_val,
    input logic              out_valid,
    input logic [ADDR_W-1:0] ea,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_val,
    input logic              user_acc,
    input logic              undef
);

    logic code_path;
    assign code_path = (hw0[3:0] != 4'hF) && !hw0[7];

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(ea) && $stable(wb_val)));

    p_literal_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hw0[3:0] == 4'hF) |=> (!wb_en && !undef && !user_acc));

    p_post_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_path && hw1[11:8] == 4'h9) |=>
        (wb_en && ea == $past(base_val) && wb_val == $past(base_val) - ADDR_W'($past(hw1[7:0]))));

    p_user_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc |-> (!wb_en && !undef));

    p_undef_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!wb_en && !user_acc && ea == '0));

endmodule

bind word_load_agen word_load_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .hw0      (hw0),
    .hw1      (hw1),
    .base_val (base_val),
    .out_valid(out_valid),
    .ea       (ea),
    .wb_en    (wb_en),
    .wb_val   (wb_val),
    .user_acc (user_acc),
    .undef    (undef)
);

// File: tb/tb_word_load_agen.sv
// Directed bench for word_load_agen: one task per scenario.
module tb_word_load_agen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] hw0 = '0;
    logic [15:0] hw1 = '0;
    logic [31:0] pc = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic        out_valid;
    logic [31:0] ea;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        user_acc;
    logic        undef;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    word_load_agen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hw0(hw0), .hw1(hw1), .pc(pc), .base_val(base_val), .index_val(index_val),
        .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_val(wb_val),
        .user_acc(user_acc), .undef(undef)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one instruction for one cycle; results are sampled at the next negedge.
    task automatic issue(input logic [15:0] h0, input logic [15:0] h1,
                         input logic [31:0] p, input logic [31:0] b, input logic [31:0] x);
        @(negedge clk);
        hw0 = h0; hw1 = h1; pc = p; base_val = b; index_val = x; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] e_ea, input logic e_wb,
                              input logic [31:0] e_wbv, input logic e_user, input logic e_undef);
        check(req, "out_valid", 32'(out_valid), 32'd1);
        check(req, "ea", ea, e_ea);
        check(req, "wb_en", 32'(wb_en), 32'(e_wb));
        if (e_wb) check(req, "wb_val", wb_val, e_wbv);
        check(req, "user_acc", 32'(user_acc), 32'(e_user));
        check(req, "undef", 32'(undef), 32'(e_undef));
    endtask

    function automatic logic [31:0] pc_round(input logic [31:0] p);
        return (p + 32'd3) & 32'hFFFF_FFFC;
    endfunction

    task automatic t_reset();
        check("R10", "out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_literal();
        issue(16'h008F, 16'h0123, 32'h0000_1002, 32'h0, 32'h0);
        expect_out("R1", pc_round(32'h1002) + 32'h123, 1'b0, 32'h0, 1'b0, 1'b0);
        issue(16'h000F, 16'h0010, 32'h0000_1000, 32'h5555, 32'h0);
        expect_out("R1", 32'h1000 - 32'h10, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_register();
        issue(16'h0002, 16'h0030, 32'h0, 32'h100, 32'h11);
        expect_out("R2", 32'h100 + (32'h11 << 3), 1'b0, 32'h0, 1'b0, 1'b0);
        issue(16'h0002, 16'h0000, 32'h0, 32'h100, 32'h11);
        expect_out("R2", 32'h111, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_pos12();
        issue(16'h0083, 16'h0FFF, 32'h0, 32'h2000, 32'h0);
        expect_out("R3", 32'h2FFF, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_post();
        issue(16'h0004, 16'h0910, 32'h0, 32'h500, 32'h0);
        expect_out("R4", 32'h500, 1'b1, 32'h4F0, 1'b0, 1'b0);
        issue(16'h0004, 16'h0BFF, 32'h0, 32'h500, 32'h0);
        expect_out("R4", 32'h500, 1'b1, 32'h5FF, 1'b0, 1'b0);
    endtask

    task automatic t_neg();
        issue(16'h0004, 16'h0C20, 32'h0, 32'h500, 32'h0);
        expect_out("R5", 32'h4E0, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_pre();
        issue(16'h0001, 16'h0D04, 32'h0, 32'h100, 32'h0);
        expect_out("R6", 32'hFC, 1'b1, 32'hFC, 1'b0, 1'b0);
        issue(16'h0001, 16'h0F80, 32'h0, 32'h100, 32'h0);
        expect_out("R6", 32'h180, 1'b1, 32'h180, 1'b0, 1'b0);
    endtask

    task automatic t_user();
        issue(16'h0006, 16'h0E08, 32'h0, 32'h40, 32'h0);
        expect_out("R7", 32'h48, 1'b0, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_undef();
        issue(16'h0006, 16'h0A00, 32'h0, 32'h40, 32'h0);
        expect_out("R8", 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
        issue(16'h0006, 16'h0540, 32'h0, 32'h40, 32'h0);
        expect_out("R8", 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
        issue(16'h0006, 16'h0040, 32'h0, 32'h40, 32'h3);
        expect_out("R8", 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_wrap();
        issue(16'h0005, 16'h0F20, 32'h0, 32'hFFFF_FFF0, 32'h0);
        expect_out("R9", 32'h10, 1'b1, 32'h10, 1'b0, 1'b0);
        issue(16'h000F, 16'h0004, 32'hFFFF_FFFE, 32'h0, 32'h0);
        expect_out("R9", 32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        issue(16'h0001, 16'h0F08, 32'h0, 32'h200, 32'h0);
        expect_out("R10", 32'h208, 1'b1, 32'h208, 1'b0, 1'b0);
        hw1 = 16'h0C01; base_val = 32'h9999;
        @(negedge clk);
        check("R10", "out_valid idle", 32'(out_valid), 32'd0);
        check("R10", "ea held", ea, 32'h208);
        check("R10", "wb_val held", wb_val, 32'h208);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "out_valid cleared by reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_literal();
        t_register();
        t_pos12();
        t_post();
        t_neg();
        t_pre();
        t_user();
        t_undef();
        t_wrap();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule